// File: doc/BRIEF.md
# Character Raster Timing and Refresh Address Generator

This block produces the scan timing for a text-mode raster display from a single character clock. A column counter walks across each scan line. A line-within-row counter and a row counter walk down the frame. A short trim phase of whole scan lines can follow the last character row, so the frame height need not be a multiple of the row height. From these counters the block forms horizontal sync, a fixed-length vertical sync, a display-enable strobe, a 14-bit character memory address and the 4-bit scan-line index that selects a line of the glyph.

All timing values are static inputs that a separate register block provides. Software scrolls or flips pages by changing the frame base address, which wraps modulo 16K words. Only progressive (non-interlaced) scanning is produced. The design assumes that at least one blanked column ends each line (`cfg_h_disp` <= `cfg_h_total`), that `cfg_vs_row` <= `cfg_v_total`, and that `cfg_h_disp` is not zero.

Top module: `raster_timing_gen`

## Requirements
- R1: A scan line lasts `cfg_h_total`+1 character clocks. The column index runs from 0 up to `cfg_h_total` and then returns to 0.
- R2: `hsync` is high for exactly `cfg_hs_width` clocks, beginning at column `cfg_hs_col`. The pulse may run on into the next line. A width of 0 gives no pulse.
- R3: Each character row holds `cfg_max_raster`+1 scan lines. During row lines `raster_addr` counts 0, 1, ..., `cfg_max_raster` and steps once per line.
- R4: After the last scan line of row `cfg_v_total`, `cfg_v_trim` extra lines follow, with `raster_addr` counting 0 up to `cfg_v_trim`-1. The frame then restarts at row 0, line 0. With a trim of 0, the frame restarts straight after row `cfg_v_total`.
- R5: `vsync` goes high at the start of line 0 of row `cfg_vs_row` and stays high for exactly 16 scan lines, whole lines only. It may run on into the next frame. With `cfg_vs_row` = 0, this includes the first frame after reset.
- R6: `disp_en` is high exactly when the column is below `cfg_h_disp`, the row is below `cfg_v_disp`, and the line is not a trim line.
- R7: At column c (c < `cfg_h_disp`) of any line in row k, `mem_addr` equals `cfg_base_addr` + k·`cfg_h_disp` + c. At the start of every frame, it therefore equals `cfg_base_addr`.
- R8: From column `cfg_h_disp` to the end of the line, `mem_addr` holds `cfg_base_addr` + k·`cfg_h_disp` + `cfg_h_disp`. Trim lines use k = `cfg_v_total`+1.
- R9: `mem_addr` arithmetic wraps modulo 2^14.
- R10: While `rst_n` is low, `hsync`, `vsync` and `disp_en` are low, `raster_addr` is 0 and `mem_addr` equals `cfg_base_addr`. The first clock after release is column 0 of line 0 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_h_total | input | 8 | Characters per line minus one |
| cfg_h_disp | input | 8 | Displayed characters per line |
| cfg_hs_col | input | 8 | Column where horizontal sync begins |
| cfg_hs_width | input | 4 | Horizontal sync length in clocks (0 = none) |
| cfg_v_total | input | 7 | Character rows per frame minus one |
| cfg_v_trim | input | 5 | Extra scan lines after the last row |
| cfg_v_disp | input | 7 | Displayed character rows |
| cfg_vs_row | input | 7 | Row where vertical sync begins |
| cfg_max_raster | input | 4 | Scan lines per row minus one |
| cfg_base_addr | input | 14 | Memory address of the first character of a frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync, 16 lines long |
| disp_en | output | 1 | Active display window |
| mem_addr | output | 14 | Character memory address |
| raster_addr | output | 4 | Scan line within the current row or trim phase |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- A trim phase after the last row. A design that counts it wrongly produces frames one line long or short, or shows trim lines as displayed.
- A vertical sync that begins near the frame end and runs on into the next frame. A design that clears it at frame wrap cuts the pulse short.
- A vertical sync row of 0. A design that misses the frame start straight after reset drops the first pulse.
- A base address just below 16K, so the row address wraps. A design with a carry or width error would jump to the wrong page.
- A single-line row height and the full 16-line row height, which expose off-by-one faults in the line counter.
- A zero sync width. A design that loads width minus one without a guard would pulse for 16 clocks instead of none.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
// Package: default widths shared by the raster timing generator and its parts.
package rtg_pkg;
    localparam int RTG_H_W      = 8;   // column counter width
    localparam int RTG_HSW_W    = 4;   // horizontal sync width field
    localparam int RTG_ROW_W    = 7;   // character row counter width
    localparam int RTG_TRIM_W   = 5;   // trim scan line field
    localparam int RTG_RA_W     = 4;   // scan line index output width
    localparam int RTG_MA_W     = 14;  // memory address width
    localparam int RTG_VS_LINES = 16;  // fixed vertical sync length in lines
endpackage

// File: rtl/rtg_hcount.sv
`timescale 1ns/1ps
// Column counter and horizontal sync pulse former.
// Counts 0..h_total, flags the last column, and forms a sync pulse of hs_width
// clocks starting at column hs_col; the pulse may continue into the next line.
// Assumes static configuration inputs.
module rtg_hcount #(
    parameter int H_W   = 8,
    parameter int HSW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [H_W-1:0]   h_total,
    input  logic [H_W-1:0]   hs_col,
    input  logic [HSW_W-1:0] hs_width,
    output logic [H_W-1:0]   h_cnt,
    output logic             line_end,
    output logic             hs_raw
);
    logic [HSW_W-1:0] hs_left;
    logic             hs_start;

    // Decode line end and the sync start column.
    always_comb begin
        line_end = (h_cnt == h_total);
        hs_start = (h_cnt == hs_col) && (hs_width != '0);
        hs_raw   = hs_start || (hs_left != '0);
    end

    // Advance the column, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + 1'b1;
    end

    // Track the clocks of sync still owed after the start column.
    always_ff @(posedge clk) begin
        if (!rst_n)                hs_left <= '0;
        else if (hs_start)         hs_left <= hs_width - 1'b1;
        else if (hs_left != '0)    hs_left <= hs_left - 1'b1;
    end
endmodule

// File: rtl/rtg_vcount.sv
`timescale 1ns/1ps
// Scan line, character row and trim phase sequencer, plus vertical sync.
// Steps once per line_end. Rows hold max_raster+1 lines; after row v_total a
// trim phase of v_trim lines runs before the frame wraps. Vertical sync lasts
// VS_LINES whole lines from line 0 of row vs_row.
// Assumes vs_row <= v_total and static configuration inputs.
module rtg_vcount #(
    parameter int ROW_W    = 7,
    parameter int TRIM_W   = 5,
    parameter int RA_W     = 4,
    parameter int VS_LINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [ROW_W-1:0]  v_total,
    input  logic [TRIM_W-1:0] v_trim,
    input  logic [RA_W-1:0]   max_raster,
    input  logic [ROW_W-1:0]  vs_row,
    output logic [ROW_W-1:0]  row,
    output logic [RA_W-1:0]   raster,
    output logic              in_trim,
    output logic              row_done,
    output logic              frame_wrap,
    output logic              vs_raw
);
    localparam int CNT_W = (RA_W > TRIM_W) ? RA_W : TRIM_W;
    localparam int VS_W  = $clog2(VS_LINES + 1);

    logic [CNT_W-1:0] line_cnt;
    logic [VS_W-1:0]  vs_left;
    logic             last_line_of_row;
    logic             at_total_row;
    logic             trim_none;
    logic             trim_last;
    logic             vs_trig;

    // Decode row, trim and frame boundaries and the sync trigger.
    always_comb begin
        last_line_of_row = !in_trim && (line_cnt == CNT_W'(max_raster));
        at_total_row     = (row == v_total);
        trim_none        = (v_trim == '0);
        trim_last        = in_trim && ((line_cnt + 1'b1) == CNT_W'(v_trim));
        row_done         = line_end && last_line_of_row;
        frame_wrap       = line_end && ((last_line_of_row && at_total_row && trim_none) || trim_last);
        vs_trig          = (frame_wrap && (vs_row == '0))
                        || (row_done && !at_total_row && ((row + 1'b1) == vs_row));
        raster           = line_cnt[RA_W-1:0];
        vs_raw           = (vs_left != '0);
    end

    // Step line, row and trim state at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            row      <= '0;
            in_trim  <= 1'b0;
        end else if (frame_wrap) begin
            line_cnt <= '0;
            row      <= '0;
            in_trim  <= 1'b0;
        end else if (row_done) begin
            line_cnt <= '0;
            row      <= row + 1'b1;
            in_trim  <= at_total_row;
        end else if (line_end) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    // Count down the vertical sync lines, reloading on each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)                          vs_left <= (vs_row == '0) ? VS_W'(VS_LINES) : '0;
        else if (vs_trig)                    vs_left <= VS_W'(VS_LINES);
        else if (line_end && vs_left != '0)  vs_left <= vs_left - 1'b1;
    end
endmodule

// File: rtl/rtg_addr.sv
`timescale 1ns/1ps
// Character memory address former.
// Holds the offset of the current row from the frame base; the address is
// base + row offset + column, the column clamped at the displayed count so the
// value holds through blanking. Row offset grows by h_disp per finished row
// and clears at frame wrap. Arithmetic wraps at 2^MA_W. Assumes MA_W >= H_W.
module rtg_addr #(
    parameter int MA_W = 14,
    parameter int H_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MA_W-1:0] base_addr,
    input  logic [H_W-1:0]  h_disp,
    input  logic [H_W-1:0]  h_cnt,
    input  logic            row_done,
    input  logic            frame_wrap,
    output logic [MA_W-1:0] mem_addr
);
    logic [MA_W-1:0] row_off;
    logic [H_W-1:0]  col_off;

    // Clamp the column to the displayed width and sum the address.
    always_comb begin
        col_off  = (h_cnt < h_disp) ? h_cnt : h_disp;
        mem_addr = base_addr + row_off + MA_W'(col_off);
    end

    // Keep the running row offset within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          row_off <= '0;
        else if (frame_wrap) row_off <= '0;
        else if (row_done)   row_off <= row_off + MA_W'(h_disp);
    end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
// Raster timing and refresh address generator for a character display.
// Combines the column counter, vertical sequencer and address former; outputs
// are decoded from counter state and forced quiet while rst_n is low.
// Assumes static configuration, h_disp <= h_total, vs_row <= v_total.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int H_W      = RTG_H_W,
    parameter int HSW_W    = RTG_HSW_W,
    parameter int ROW_W    = RTG_ROW_W,
    parameter int TRIM_W   = RTG_TRIM_W,
    parameter int RA_W     = RTG_RA_W,
    parameter int MA_W     = RTG_MA_W,
    parameter int VS_LINES = RTG_VS_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    cfg_h_total,
    input  logic [H_W-1:0]    cfg_h_disp,
    input  logic [H_W-1:0]    cfg_hs_col,
    input  logic [HSW_W-1:0]  cfg_hs_width,
    input  logic [ROW_W-1:0]  cfg_v_total,
    input  logic [TRIM_W-1:0] cfg_v_trim,
    input  logic [ROW_W-1:0]  cfg_v_disp,
    input  logic [ROW_W-1:0]  cfg_vs_row,
    input  logic [RA_W-1:0]   cfg_max_raster,
    input  logic [MA_W-1:0]   cfg_base_addr,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic [MA_W-1:0]   mem_addr,
    output logic [RA_W-1:0]   raster_addr
);
    logic [H_W-1:0]   h_cnt;
    logic             line_end;
    logic             hs_raw;
    logic [ROW_W-1:0] row;
    logic [RA_W-1:0]  raster;
    logic             in_trim;
    logic             row_done;
    logic             frame_wrap;
    logic             vs_raw;

    rtg_hcount #(.H_W(H_W), .HSW_W(HSW_W)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_total  (cfg_h_total),
        .hs_col   (cfg_hs_col),
        .hs_width (cfg_hs_width),
        .h_cnt    (h_cnt),
        .line_end (line_end),
        .hs_raw   (hs_raw)
    );

    rtg_vcount #(.ROW_W(ROW_W), .TRIM_W(TRIM_W), .RA_W(RA_W), .VS_LINES(VS_LINES)) u_v (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .v_total    (cfg_v_total),
        .v_trim     (cfg_v_trim),
        .max_raster (cfg_max_raster),
        .vs_row     (cfg_vs_row),
        .row        (row),
        .raster     (raster),
        .in_trim    (in_trim),
        .row_done   (row_done),
        .frame_wrap (frame_wrap),
        .vs_raw     (vs_raw)
    );

    rtg_addr #(.MA_W(MA_W), .H_W(H_W)) u_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_addr  (cfg_base_addr),
        .h_disp     (cfg_h_disp),
        .h_cnt      (h_cnt),
        .row_done   (row_done),
        .frame_wrap (frame_wrap),
        .mem_addr   (mem_addr)
    );

    // Gate the decoded outputs with reset and form the display window.
    always_comb begin
        hsync       = rst_n && hs_raw;
        vsync       = rst_n && vs_raw;
        disp_en     = rst_n && !in_trim && (row < cfg_v_disp) && (h_cnt < cfg_h_disp);
        raster_addr = raster;
    end
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
// Checker for raster_timing_gen: port-level timing properties.
module rtg_checker #(
    parameter int MA_W  = 14,
    parameter int RA_W  = 4,
    parameter int HSW_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [HSW_W-1:0] cfg_hs_width,
    input logic             hsync,
    input logic             vsync,
    input logic             disp_en,
    input logic [MA_W-1:0]  mem_addr,
    input logic [RA_W-1:0]  raster_addr
);
    logic [7:0] hs_run;

    // Count consecutive clocks with hsync high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hs_run <= '0;
        else if (!hsync)             hs_run <= '0;
        else if (hs_run != 8'hFF)    hs_run <= hs_run + 1'b1;
    end

    // R10
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!hsync && !vsync && !disp_en && raster_addr == '0);
        end
    end

    // R2
    hs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |-> (hs_run == 8'(cfg_hs_width)));

    // R7
    ma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && $past(disp_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R5
    vs_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (raster_addr == '0));
endmodule

bind raster_timing_gen rtg_checker #(.MA_W(MA_W), .RA_W(RA_W), .HSW_W(HSW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_hs_width (cfg_hs_width),
    .hsync        (hsync),
    .vsync        (vsync),
    .disp_en      (disp_en),
    .mem_addr     (mem_addr),
    .raster_addr  (raster_addr)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  h_total, h_disp, hs_col;
    logic [3:0]  hs_width;
    logic [6:0]  v_total, v_disp, vs_row;
    logic [4:0]  v_trim;
    logic [3:0]  max_raster;
    logic [13:0] base_addr;
    logic        hsync, vsync, disp_en;
    logic [13:0] mem_addr;
    logic [3:0]  raster_addr;

    typedef struct {
        logic        hs;
        logic        vs;
        logic        de;
        logic [13:0] ma;
        logic [3:0]  ra;
        bit          trim;
    } exp_t;

    exp_t  q[$];
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    int    checks = 0;
    int    errors = 0;
    string ma_tag = "R7";
    int    hs_rem;
    int    vs_rem;

    always #4 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_h_total(h_total), .cfg_h_disp(h_disp), .cfg_hs_col(hs_col),
        .cfg_hs_width(hs_width), .cfg_v_total(v_total), .cfg_v_trim(v_trim),
        .cfg_v_disp(v_disp), .cfg_vs_row(vs_row), .cfg_max_raster(max_raster),
        .cfg_base_addr(base_addr),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .mem_addr(mem_addr), .raster_addr(raster_addr)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Build expected outputs for one scan line (R1..R9 model from the requirements).
    task automatic push_line(int row, int ln, bit trim, logic [13:0] rbase);
        exp_t it;
        if (!trim && ln == 0 && row == int'(vs_row)) vs_rem = 16;
        for (int h = 0; h <= int'(h_total); h++) begin
            if (h == int'(hs_col) && hs_width != 0) hs_rem = int'(hs_width);
            it.hs   = (hs_rem > 0);
            if (hs_rem > 0) hs_rem--;
            it.vs   = (vs_rem > 0);
            it.de   = !trim && (row < int'(v_disp)) && (h < int'(h_disp));
            it.ma   = rbase + 14'((h < int'(h_disp)) ? h : int'(h_disp));
            it.ra   = 4'(ln);
            it.trim = trim;
            q.push_back(it);
        end
        if (vs_rem > 0) vs_rem--;
    endtask

    // Driver: push whole frames of expected items.
    task automatic push_frames(int n);
        logic [13:0] rbase;
        for (int f = 0; f < n; f++) begin
            rbase = base_addr;
            for (int r = 0; r <= int'(v_total); r++) begin
                for (int l = 0; l <= int'(max_raster); l++) push_line(r, l, 1'b0, rbase);
                rbase = rbase + 14'(h_disp);
            end
            for (int t = 0; t < int'(v_trim); t++) push_line(int'(v_total) + 1, t, 1'b1, rbase);
        end
    endtask

    // Monitor: pop and compare once per clock, mid low phase.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (mon_en && q.size() > 0) begin
                e = q.pop_front();
                chk(hsync == e.hs, "R1/R2", "hsync", int'(hsync), int'(e.hs));
                chk(vsync == e.vs, "R5", "vsync", int'(vsync), int'(e.vs));
                chk(disp_en == e.de, "R6", "disp_en", int'(disp_en), int'(e.de));
                chk(raster_addr == e.ra, e.trim ? "R4" : "R3", "raster_addr",
                    int'(raster_addr), int'(e.ra));
                chk(mem_addr == e.ma, e.de ? ma_tag : "R8", "mem_addr",
                    int'(mem_addr), int'(e.ma));
            end
        end
    end

    // Apply a configuration under reset, check the reset state, run frames.
    task automatic run_cfg(int ht, int hd, int hc, int hw, int vt, int vtr,
                           int vd, int vr, int mr, int ba, int frames, string tag);
        @(negedge clk);
        rst_n = 1'b0;
        h_total = 8'(ht); h_disp = 8'(hd); hs_col = 8'(hc); hs_width = 4'(hw);
        v_total = 7'(vt); v_trim = 5'(vtr); v_disp = 7'(vd); vs_row = 7'(vr);
        max_raster = 4'(mr); base_addr = 14'(ba); ma_tag = tag;
        repeat (3) @(negedge clk);
        #2;
        // R10: quiet outputs and base address while held in reset
        chk(!hsync && !vsync && !disp_en, "R10", "syncs/enable in reset",
            int'({hsync, vsync, disp_en}), 0);
        chk(raster_addr == 0, "R10", "raster_addr in reset", int'(raster_addr), 0);
        chk(mem_addr == base_addr, "R10", "mem_addr in reset", int'(mem_addr), int'(base_addr));
        hs_rem = 0;
        vs_rem = 0;
        push_frames(frames);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        wait (q.size() == 0);
        @(negedge clk);
        mon_en = 1'b0;
        rst_n = 1'b0;
    endtask

    initial begin
        h_total = 0; h_disp = 1; hs_col = 0; hs_width = 0;
        v_total = 0; v_trim = 0; v_disp = 0; vs_row = 0;
        max_raster = 0; base_addr = 0;
        // R4 R5: trim lines, vsync running into the next frame
        run_cfg(19, 12, 14, 3, 7, 3, 5, 6, 3, 'h0100, 2, "R7");
        // R9 R3: one-line rows, address wraps past 16K
        run_cfg(9, 6, 7, 2, 19, 0, 18, 2, 0, 'h3FF8, 2, "R9");
        // R2 R3 R5: no hsync, 16-line rows, vsync from row 0 after reset
        run_cfg(7, 4, 2, 0, 1, 1, 2, 0, 15, 'h0020, 2, "R7");
        // R2: hsync crossing the line end
        run_cfg(11, 6, 10, 5, 3, 2, 3, 1, 1, 'h1000, 1, "R7");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule